// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic datapath of a small accumulator processor. It takes the accumulator, one 8-bit operand and the current carry. It forms a result with no clock in the path, and it says whether that result goes back into the accumulator. A group select picks one of four families of work: eight two-operand operations, four accumulator rotates, operand increment and operand decrement. Inside the two-operand family a 3-bit code chooses the operation.

Four condition flags (carry, zero, sign, parity) live in a small register inside the block. They load on the rising clock edge only when the update strobe is high, and each family writes only the flags it owns. The surrounding sequencer fetches operands, feeds the registered carry back on the carry input, and writes increment and decrement results into the register file. All control pins are plain levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `acc_alu`

## Requirements
- R1: With group 0 (two-operand) and code 0, the result is accumulator + operand. The 9th bit of that sum becomes the carry flag.
- R2: Code 1 adds the operand and the carry input to the accumulator. The carry flag takes bit 8 of the 9-bit total.
- R3: Code 2 gives accumulator − operand, and code 3 gives accumulator − (operand + carry input). In both, bit 8 of the 9-bit difference is a borrow and is stored as carry.
- R4: Codes 4 (AND), 5 (XOR) and 6 (OR) give the bitwise result and always clear the carry flag.
- R5: Code 7 (compare) sets all four flags as code 2 would. Its accumulator write enable is 0, and the result output shows the difference.
- R6: Zero is set when the low 8 bits of the result are all 0. Sign is a copy of result bit 7.
- R7: Parity is 1 when the result holds an even number of 1 bits, and 0 when the count is odd.
- R8: Group 2 gives operand + 1 and group 3 gives operand − 1, both modulo 256. They update zero, sign and parity, keep the stored carry, and hold the accumulator write enable at 0.
- R9: Group 1 with rotate code 0 rotates the accumulator left, and bit 7 goes to both bit 0 and carry. Rotate code 1 rotates it right, and bit 0 goes to both bit 7 and carry.
- R10: Rotate code 2 shifts left and code 3 shifts right. Each puts the carry input into the vacated end bit and loads carry from the bit shifted out.
- R11: Rotates update only carry. Zero, sign and parity keep their stored values.
- R12: A synchronous active-high reset clears all four flags. With the strobe low, no flag changes.
- R13: The accumulator write enable is 1 for codes 0 to 6 of group 0 and for every rotate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_group | input | 2 | 0 two-operand, 1 rotate, 2 increment, 3 decrement |
| op_code | input | 3 | Operation within group 0; low two bits pick the rotate in group 1 |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand, or the register for increment and decrement |
| carry_in | input | 1 | Current carry, fed back by the sequencer |
| flag_we | input | 1 | Flag update strobe |
| result | output | 8 | Combinational result |
| acc_we | output | 1 | Write the result into the accumulator |
| flag_c | output | 1 | Registered carry |
| flag_z | output | 1 | Registered zero |
| flag_s | output | 1 | Registered sign |
| flag_p | output | 1 | Registered parity |

## Verification
The bench targets the wrap cases of the carry chain:
- 0x80 + 0x80: a lost bit 8 would leave carry clear while zero is set.
- 0xFF + 0 with carry in.
- Subtract with borrow where operand plus carry passes the accumulator: a design that drops the carry term reports no borrow.

It then runs an increment from 0xFF and a decrement from 0x00 with carry set. A design that touches carry there clears it.

It also runs rotates after flags are set, to catch any rotate that rewrites zero, sign or parity. Compare with equal inputs checks that the accumulator enable stays low while zero goes high. Random operations with the strobe held low show whether any flag leaks through.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [1:0] {
    GRP_TWO = 2'd0,
    GRP_ROT = 2'd1,
    GRP_INC = 2'd2,
    GRP_DEC = 2'd3
  } grp_t;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } op_t;

  typedef enum logic [1:0] {
    ROT_LC = 2'd0,
    ROT_RC = 2'd1,
    ROT_LT = 2'd2,
    ROT_RT = 2'd3
  } rot_t;
endpackage

// File: rtl/alu_twoop.sv
module alu_twoop
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic [2:0]    code,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int XW = DW + 1;
  logic [XW-1:0] ax, bx, cx, wide;

  assign ax = {1'b0, a};
  assign bx = {1'b0, b};
  assign cx = {{DW{1'b0}}, cin};

  always_comb begin
    unique case (op_t'(code))
      OP_ADD:  wide = ax + bx;
      OP_ADC:  wide = ax + bx + cx;
      OP_SUB:  wide = ax - bx;
      OP_SBB:  wide = ax - (bx + cx);
      OP_AND:  wide = {1'b0, a & b};
      OP_XOR:  wide = {1'b0, a ^ b};
      OP_OR:   wide = {1'b0, a | b};
      default: wide = ax - bx;
    endcase
  end

  assign res  = wide[DW-1:0];
  assign cout = wide[DW];
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic [1:0]    mode,
  output logic [DW-1:0] res,
  output logic          cout
);
  always_comb begin
    unique case (rot_t'(mode))
      ROT_LC: begin res = {a[DW-2:0], a[DW-1]}; cout = a[DW-1]; end
      ROT_RC: begin res = {a[0], a[DW-1:1]};    cout = a[0];    end
      ROT_LT: begin res = {a[DW-2:0], cin};     cout = a[DW-1]; end
      default: begin res = {cin, a[DW-1:1]};    cout = a[0];    end
    endcase
  end
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic upd_c,
  input  logic upd_zsp,
  input  logic c_nxt,
  input  logic z_nxt,
  input  logic s_nxt,
  input  logic p_nxt,
  output logic c_q,
  output logic z_q,
  output logic s_q,
  output logic p_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
      s_q <= 1'b0;
      p_q <= 1'b0;
    end else if (we) begin
      if (upd_c) c_q <= c_nxt;
      if (upd_zsp) begin
        z_q <= z_nxt;
        s_q <= s_nxt;
        p_q <= p_nxt;
      end
    end
  end

  AST_FLAGS_CLEAR_ON_RESET: assert property (@(posedge clk) rst |=> ({c_q, z_q, s_q, p_q} == 4'b0)); // R12
  AST_FLAGS_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst) !we |=> $stable({c_q, z_q, s_q, p_q})); // R12
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    op_group,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd_in,
  input  logic          carry_in,
  input  logic          flag_we,
  output logic [DW-1:0] result,
  output logic          acc_we,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_s,
  output logic          flag_p
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  grp_t          grp;
  logic [DW-1:0] two_res, rot_res;
  logic          two_c, rot_c;
  logic          upd_c, upd_zsp, c_nxt;

  assign grp = grp_t'(op_group);

  alu_twoop #(.DW(DW)) u_twoop (
    .a(acc_in), .b(opnd_in), .cin(carry_in), .code(op_code),
    .res(two_res), .cout(two_c)
  );

  alu_rotate #(.DW(DW)) u_rotate (
    .a(acc_in), .cin(carry_in), .mode(op_code[1:0]),
    .res(rot_res), .cout(rot_c)
  );

  always_comb begin
    unique case (grp)
      GRP_TWO: begin
        result  = two_res;
        c_nxt   = two_c;
        upd_c   = 1'b1;
        upd_zsp = 1'b1;
        acc_we  = (op_t'(op_code) != OP_CMP);
      end
      GRP_ROT: begin
        result  = rot_res;
        c_nxt   = rot_c;
        upd_c   = 1'b1;
        upd_zsp = 1'b0;
        acc_we  = 1'b1;
      end
      GRP_INC: begin
        result  = opnd_in + ONE;
        c_nxt   = 1'b0;
        upd_c   = 1'b0;
        upd_zsp = 1'b1;
        acc_we  = 1'b0;
      end
      default: begin
        result  = opnd_in - ONE;
        c_nxt   = 1'b0;
        upd_c   = 1'b0;
        upd_zsp = 1'b1;
        acc_we  = 1'b0;
      end
    endcase
  end

  alu_flagreg u_flags (
    .clk(clk), .rst(rst), .we(flag_we),
    .upd_c(upd_c), .upd_zsp(upd_zsp),
    .c_nxt(c_nxt), .z_nxt(~|result), .s_nxt(result[DW-1]), .p_nxt(~^result),
    .c_q(flag_c), .z_q(flag_z), .s_q(flag_s), .p_q(flag_p)
  );

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (flag_we && grp == GRP_TWO && op_code inside {3'd4, 3'd5, 3'd6}) |=> !flag_c); // R4
  AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (grp == GRP_INC || grp == GRP_DEC)) |=> flag_c == $past(flag_c)); // R8
  AST_ROT_KEEPS_ZSP: assert property (@(posedge clk) disable iff (rst)
    (flag_we && grp == GRP_ROT) |=> $stable({flag_z, flag_s, flag_p})); // R11
  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (flag_we && grp != GRP_ROT) |=> flag_z == ($past(result) == '0)); // R6
  AST_SIGN_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (flag_we && grp != GRP_ROT) |=> flag_s == $past(result[DW-1])); // R6
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] op_group;
  logic [2:0] op_code;
  logic [7:0] acc_in, opnd_in;
  logic       carry_in, flag_we;
  logic [7:0] result;
  logic       acc_we, flag_c, flag_z, flag_s, flag_p;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int mc, mz, ms, mp;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst(rst), .op_group(op_group), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in), .flag_we(flag_we),
    .result(result), .acc_we(acc_we),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic string op_tag(int g, int c);
    if (g == 1) return (c[1] ? "R10" : "R9");
    if (g >= 2) return "R8";
    case (c)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      7: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(int g, int c, int a, int b, int ci, int we);
    int r, w, nc, uc, uz;
    @(negedge clk);
    op_group = g[1:0]; op_code = c[2:0];
    acc_in = a[7:0]; opnd_in = b[7:0]; carry_in = ci[0]; flag_we = we[0];
    uc = 1; uz = 1; nc = 0; w = 0;
    case (g)
      0: begin
        case (c)
          0: r = a + b;
          1: r = a + b + ci;
          2, 7: r = a - b;
          3: r = a - (b + ci);
          4: r = a & b;
          5: r = a ^ b;
          default: r = a | b;
        endcase
        nc = (r >> 8) & 1;
        w = (c != 7);
      end
      1: begin
        uz = 0; w = 1;
        case (c & 3)
          0: begin r = (a << 1) | (a >> 7); nc = a >> 7; end
          1: begin r = (a >> 1) | ((a & 1) << 7); nc = a & 1; end
          2: begin r = (a << 1) | ci; nc = a >> 7; end
          default: begin r = (a >> 1) | (ci << 7); nc = a & 1; end
        endcase
      end
      2: begin r = b + 1; uc = 0; end
      default: begin r = b - 1; uc = 0; end
    endcase
    r = r & 255;
    #1;
    chk(op_tag(g, c), "result", int'(result), r);
    chk((g == 0) ? ((c == 7) ? "R5" : "R13") : ((g == 1) ? "R13" : "R8"), "acc_we", int'(acc_we), w);
    @(posedge clk);
    #1;
    if (we) begin
      if (uc) mc = nc;
      if (uz) begin
        mz = (r == 0);
        ms = (r >> 7) & 1;
        mp = ((ones(r) & 1) == 0);
      end
    end
    chk(!we ? "R12" : (uc ? op_tag(g, c) : "R8"), "flag_c", int'(flag_c), mc);
    chk(!we ? "R12" : (uz ? "R6" : "R11"), "flag_z", int'(flag_z), mz);
    chk(!we ? "R12" : (uz ? "R6" : "R11"), "flag_s", int'(flag_s), ms);
    chk(!we ? "R12" : (uz ? "R7" : "R11"), "flag_p", int'(flag_p), mp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    mc = 0; mz = 0; ms = 0; mp = 0;
    chk("R12", "reset flags", int'({flag_c, flag_z, flag_s, flag_p}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_group = 0; op_code = 0; acc_in = 0; opnd_in = 0;
    carry_in = 0; flag_we = 1'b1;
    mc = 0; mz = 0; ms = 0; mp = 0;
    repeat (2) @(posedge clk);
    do_reset();
    apply(0, 0, 8'h80, 8'h80, 0, 1);   // R1 wrap to zero with carry
    apply(0, 0, 8'h12, 8'h34, 1, 1);   // R1 carry_in ignored
    apply(0, 1, 8'hFF, 8'h00, 1, 1);   // R2
    apply(0, 2, 8'h05, 8'h06, 0, 1);   // R3 borrow
    apply(0, 3, 8'h05, 8'h05, 1, 1);   // R3 borrow via carry term
    apply(0, 3, 8'h10, 8'hFF, 1, 1);   // R3 operand+carry overflow
    apply(0, 4, 8'hF0, 8'h0F, 1, 1);   // R4 and to zero
    apply(0, 0, 8'hFF, 8'h01, 0, 1);   // set carry
    apply(0, 5, 8'hAA, 8'h55, 1, 1);   // R4 xor clears carry
    apply(0, 6, 8'h03, 8'h00, 0, 1);   // R4 / R7 parity even
    apply(0, 7, 8'h42, 8'h42, 0, 1);   // R5 equal
    apply(0, 7, 8'h01, 8'h02, 0, 1);   // R5 borrow
    apply(0, 0, 8'hFF, 8'h01, 0, 1);   // set carry
    apply(2, 0, 8'h00, 8'hFF, 1, 1);   // R8 inc wrap, carry kept
    apply(3, 0, 8'h00, 8'h00, 1, 1);   // R8 dec wrap
    apply(1, 0, 8'h81, 8'h00, 0, 1);   // R9 rlc
    apply(1, 1, 8'h01, 8'h00, 0, 1);   // R9 rrc
    apply(1, 2, 8'h40, 8'h00, 1, 1);   // R10 ral carry in
    apply(1, 3, 8'h02, 8'h00, 1, 1);   // R10 rar carry in
    apply(0, 6, 8'h00, 8'h00, 0, 1);   // zero flag set
    apply(1, 0, 8'hFF, 8'h00, 0, 1);   // R11 rotate keeps zsp
    apply(0, 0, 8'h7F, 8'h01, 0, 0);   // R12 strobe low
    for (int i = 0; i < 400; i++) begin
      int rv = $urandom;
      apply(rv & 3, (rv >> 2) & 7, (rv >> 5) & 255, (rv >> 13) & 255,
            (rv >> 21) & 1, ((rv >> 22) & 3) != 0);
      if (i == 200) do_reset();
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule